// File: doc/BRIEF.md
# Dual-Bank Design Key Store

This block keeps a 256-bit design-protection key for an on-chip configuration decryptor. The key can live in either of two banks. One is a rewritable register bank that holds its contents while a backup supply is present. The other is a write-once bank that models one-time-programmable fuses. Each bank carries a presence flag that rises when a key has been written into it.

Keys enter bit by bit through a serial shift port of the kind a test-access data register would drive. A commit strobe then copies the assembled value into the bank named by a select input. The fuse bank accepts exactly one commit. Every later attempt leaves it untouched and raises a reject flag. The block drives the chosen key to the cipher on a parallel port only. No path leads stored key bits back out through the serial port.

The selection policy works as follows. The rewritable key wins when it is present. Otherwise the fuse key is offered. With neither present, a no-key flag is raised and the key output is held at zero. The core reset clears the shift register, the fuse model and the reject flag. It does not clear the rewritable bank, which only the backup supply clears.

Top module: `key_store`

## Requirements
- R1: While shift_en_i is high, each clock edge shifts shift_bit_i into the staging register, least significant bit first. After 256 shifts, the bit shifted in at step i (counting from 0) sits at key bit i.
- R2: A commit samples the staging register as it stood before the edge. A shift in the same cycle affects only later commits.
- R3: After the first fuse commit (bank_sel_i=1), further fuse commits leave the fuse key unchanged.
- R4: A fuse commit while the fuse flag is already set raises fuse_rej_o for exactly the one cycle after that edge. In all other cycles fuse_rej_o is low.
- R5: The first fuse commit loads the fuse key and sets fuse_present_o. The flag then stays set until core reset.
- R6: A rewritable commit (bank_sel_i=0) with bat_ok_i high loads the key and sets vol_present_o. Later rewritable commits overwrite the key.
- R7: While bat_ok_i is low, the rewritable key and vol_present_o are cleared at once, and rewritable commits have no effect.
- R8: Asserting rst_ni low clears the staging register, the fuse bank, its flag and fuse_rej_o. It keeps the rewritable key and flag while bat_ok_i stays high.
- R9: key_o carries the rewritable key when vol_present_o is high. Otherwise it carries the fuse key when fuse_present_o is high.
- R10: When neither flag is set, no_key_o is high and key_o is all zeros. Otherwise no_key_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous core reset |
| bat_ok_i | input | 1 | Backup supply present; low clears the rewritable bank |
| shift_en_i | input | 1 | Shift one serial bit into the staging register |
| shift_bit_i | input | 1 | Serial key bit |
| commit_i | input | 1 | Copy the staging register into the selected bank |
| bank_sel_i | input | 1 | Commit target: 0 rewritable, 1 fuse |
| key_o | output | 256 | Key offered to the cipher |
| vol_present_o | output | 1 | Rewritable bank holds a key |
| fuse_present_o | output | 1 | Fuse bank holds a key |
| no_key_o | output | 1 | No key in either bank |
| fuse_rej_o | output | 1 | Fuse write refused on the previous edge |

## Verification
Every bank update and both presence flags follow one clock edge after the commit. key_o and no_key_o follow the banks combinationally, so they are also valid one edge after the commit. fuse_rej_o is registered and is high only in the cycle after the refused commit. Clearing by bat_ok_i or rst_ni acts asynchronously, in the same cycle. The bench changes inputs 2 ns after each rising edge and advances a behavioural model on that edge. It compares every output against the model at the falling edge, so each result is checked in the first cycle it is due.

// File: rtl/key_store_pkg.sv
package key_store_pkg;
  typedef enum logic {
    BANK_VOL  = 1'b0,
    BANK_FUSE = 1'b1
  } bank_e;
endpackage

// File: rtl/key_shift_reg.sv
module key_shift_reg #(
  parameter int unsigned KEY_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             shift_bit_i,
  output logic [KEY_W-1:0] data_o
);
  logic [KEY_W-1:0] sr_q;

  // new bit enters at MSB so the first bit ends at position 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= {shift_bit_i, sr_q[KEY_W-1:1]};
  end

  assign data_o = sr_q;

  assert_shift_in_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> data_o[KEY_W-1] == $past(shift_bit_i));
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(data_o));
endmodule

// File: rtl/vol_key_bank.sv
module vol_key_bank #(
  parameter int unsigned KEY_W = 256
) (
  input  logic             clk_i,
  input  logic             bat_ok_i,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] wr_data_i,
  output logic [KEY_W-1:0] key_o,
  output logic             vfy_o
);
  logic [KEY_W-1:0] key_q;
  logic             vfy_q;

  // only the backup supply clears this bank; core reset does not
  always_ff @(posedge clk_i or negedge bat_ok_i) begin
    if (!bat_ok_i) begin
      key_q <= '0;
      vfy_q <= 1'b0;
    end else if (wr_i) begin
      key_q <= wr_data_i;
      vfy_q <= 1'b1;
    end
  end

  assign key_o = key_q;
  assign vfy_o = vfy_q;

  assert_vol_load_R6: assert property (@(posedge clk_i) disable iff (!bat_ok_i)
    wr_i |=> vfy_o && key_o == $past(wr_data_i));
  assert_vol_keep_R6: assert property (@(posedge clk_i) disable iff (!bat_ok_i)
    !wr_i |=> $stable(key_o) && $stable(vfy_o));
endmodule

// File: rtl/fuse_key_bank.sv
module fuse_key_bank #(
  parameter int unsigned KEY_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] wr_data_i,
  output logic [KEY_W-1:0] key_o,
  output logic             vfy_o,
  output logic             rej_o
);
  logic [KEY_W-1:0] key_q;
  logic             vfy_q;
  logic             rej_q;
  logic             burn;

  assign burn = wr_i && !vfy_q;

  // rst_ni stands in for the blank array at power-on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      vfy_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      rej_q <= wr_i && vfy_q;
      if (burn) begin
        key_q <= wr_data_i;
        vfy_q <= 1'b1;
      end
    end
  end

  assign key_o = key_q;
  assign vfy_o = vfy_q;
  assign rej_o = rej_q;

  assert_fuse_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_o |=> $stable(key_o));
  assert_fuse_rej_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && vfy_o) |=> rej_o);
  assert_fuse_norej_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && vfy_o) |=> !rej_o);
  assert_fuse_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_o |=> vfy_o);
endmodule

// File: rtl/key_select.sv
module key_select #(
  parameter int unsigned KEY_W = 256
) (
  input  logic [KEY_W-1:0] vol_key_i,
  input  logic             vol_vfy_i,
  input  logic [KEY_W-1:0] fuse_key_i,
  input  logic             fuse_vfy_i,
  output logic [KEY_W-1:0] key_o,
  output logic             no_key_o
);
  always_comb begin
    key_o = '0;
    if (vol_vfy_i)       key_o = vol_key_i;
    else if (fuse_vfy_i) key_o = fuse_key_i;
  end

  assign no_key_o = !(vol_vfy_i || fuse_vfy_i);

  always_comb begin
    assert_nokey_zero_R10: assert (!no_key_o || key_o == '0);
  end
endmodule

// File: rtl/key_store.sv
module key_store
  import key_store_pkg::*;
#(
  parameter int unsigned KEY_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bat_ok_i,
  input  logic             shift_en_i,
  input  logic             shift_bit_i,
  input  logic             commit_i,
  input  logic             bank_sel_i,
  output logic [KEY_W-1:0] key_o,
  output logic             vol_present_o,
  output logic             fuse_present_o,
  output logic             no_key_o,
  output logic             fuse_rej_o
);
  bank_e            sel;
  logic [KEY_W-1:0] stage;
  logic [KEY_W-1:0] vol_key, fuse_key;
  logic             vol_vfy, fuse_vfy;
  logic             vol_wr, fuse_wr;

  assign sel     = bank_e'(bank_sel_i);
  assign vol_wr  = commit_i && (sel == BANK_VOL);
  assign fuse_wr = commit_i && (sel == BANK_FUSE);

  key_shift_reg #(.KEY_W(KEY_W)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en_i),
    .shift_bit_i(shift_bit_i),
    .data_o     (stage)
  );

  vol_key_bank #(.KEY_W(KEY_W)) u_vol (
    .clk_i    (clk_i),
    .bat_ok_i (bat_ok_i),
    .wr_i     (vol_wr),
    .wr_data_i(stage),
    .key_o    (vol_key),
    .vfy_o    (vol_vfy)
  );

  fuse_key_bank #(.KEY_W(KEY_W)) u_fuse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (fuse_wr),
    .wr_data_i(stage),
    .key_o    (fuse_key),
    .vfy_o    (fuse_vfy),
    .rej_o    (fuse_rej_o)
  );

  key_select #(.KEY_W(KEY_W)) u_sel (
    .vol_key_i (vol_key),
    .vol_vfy_i (vol_vfy),
    .fuse_key_i(fuse_key),
    .fuse_vfy_i(fuse_vfy),
    .key_o     (key_o),
    .no_key_o  (no_key_o)
  );

  assign vol_present_o  = vol_vfy;
  assign fuse_present_o = fuse_vfy;

  assert_commit_pre_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !bat_ok_i)
    (commit_i && !bank_sel_i) |=> key_o == $past(stage));
  assert_vol_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !bat_ok_i)
    (vol_present_o && fuse_present_o) |-> key_o == vol_key);
  assert_bat_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bat_ok_i |-> !vol_present_o);
endmodule

// File: tb/key_store_test.sv
module key_store_test;
  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bat_ok = 1'b0;
  logic         shift_en = 1'b0, shift_bit = 1'b0, commit = 1'b0, bank_sel = 1'b0;
  logic [W-1:0] key;
  logic         vol_p, fuse_p, no_key, rej;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_sr = '0, m_vol = '0, m_fuse = '0;
  logic         m_vv = 0, m_fv = 0, m_rej = 0;

  always #4 clk = ~clk;

  key_store uut (
    .clk_i(clk), .rst_ni(rst_ni), .bat_ok_i(bat_ok),
    .shift_en_i(shift_en), .shift_bit_i(shift_bit),
    .commit_i(commit), .bank_sel_i(bank_sel),
    .key_o(key), .vol_present_o(vol_p), .fuse_present_o(fuse_p),
    .no_key_o(no_key), .fuse_rej_o(rej)
  );

  always @(negedge bat_ok) begin m_vol = '0; m_vv = 0; end
  always @(negedge rst_ni) begin m_sr = '0; m_fuse = '0; m_fv = 0; m_rej = 0; end

  always @(posedge clk) begin
    if (!bat_ok) begin m_vol = '0; m_vv = 0; end
    if (rst_ni) begin
      m_rej = 0;
      if (commit && !bank_sel && bat_ok) begin m_vol = m_sr; m_vv = 1; end
      if (commit && bank_sel) begin
        if (m_fv) m_rej = 1;
        else begin m_fuse = m_sr; m_fv = 1; end
      end
      if (shift_en) m_sr = {shift_bit, m_sr[W-1:1]};
    end
  end

  function automatic logic [W-1:0] exp_key();
    if (m_vv) return m_vol;
    if (m_fv) return m_fuse;
    return '0;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // every-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R9_key", key, exp_key());
      chk("R10_nokey", W'(no_key), W'(!(m_vv || m_fv)));
      chk("R6_vol_flag", W'(vol_p), W'(m_vv));
      chk("R5_fuse_flag", W'(fuse_p), W'(m_fv));
      chk("R4_rej", W'(rej), W'(m_rej));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic shift_key(input logic [W-1:0] k);
    for (int i = 0; i < W; i++) begin
      shift_en = 1'b1; shift_bit = k[i];
      step();
    end
    shift_en = 1'b0; shift_bit = 1'b0;
  endtask

  task automatic do_commit(input logic sel);
    commit = 1'b1; bank_sel = sel;
    step();
    commit = 1'b0; bank_sel = 1'b0;
  endtask

  task automatic look(input string req, input logic [W-1:0] exp);
    @(negedge clk);
    chk(req, key, exp);
    step();
  endtask

  logic [W-1:0] ka, kb, kc, kd;

  initial begin
    ka = {8{32'hA5A5_0001}};
    kb = {8{32'h0F1E_2D3C}} ^ W'(1);
    kc = {W{1'b1}} ^ (W'(1) << (W-1));
    kd = {4{64'h1234_5678_9ABC_DEF0}};
    step(); step();
    bat_ok = 1'b1; rst_ni = 1'b1;
    step();
    @(negedge clk);
    chk("R10_reset_nokey", W'(no_key), W'(1));
    chk("R10_reset_zero", key, '0);
    step();

    // R1 R6: rewritable load, LSB first
    shift_key(ka);
    do_commit(1'b0);
    look("R1_R6_vol_load", ka);

    // R5 R9: fuse load, rewritable still wins
    shift_key(kb);
    do_commit(1'b1);
    look("R9_vol_priority", ka);

    // R7: backup lost, fuse key exposed, rewritable commit ignored
    bat_ok = 1'b0;
    @(negedge clk);
    chk("R7_clear_now", W'(vol_p), W'(0));
    chk("R7_fuse_shown", key, kb);
    step();
    shift_key(kc);
    do_commit(1'b0);
    look("R7_commit_ignored", kb);

    // R3 R4: second fuse commit refused
    do_commit(1'b1);
    @(negedge clk);
    chk("R4_rej_pulse", W'(rej), W'(1));
    chk("R3_fuse_kept", key, kb);
    step();
    @(negedge clk);
    chk("R4_rej_one_cycle", W'(rej), W'(0));
    step();

    // R6: rewrite allowed once backup returns
    bat_ok = 1'b1;
    step();
    do_commit(1'b0);
    look("R6_vol_rewrite", kc);

    // R2: commit and shift in the same cycle
    shift_key(kd);
    commit = 1'b1; bank_sel = 1'b0; shift_en = 1'b1; shift_bit = 1'b0;
    step();
    commit = 1'b0; shift_en = 1'b0;
    look("R2_pre_shift_value", kd);
    do_commit(1'b0);
    look("R2_later_commit", {1'b0, kd[W-1:1]});

    // R8: core reset keeps rewritable, clears fuse
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R8_vol_kept", W'(vol_p), W'(1));
    chk("R8_fuse_cleared", W'(fuse_p), W'(0));
    step();
    rst_ni = 1'b1;
    step();
    do_commit(1'b1);
    @(negedge clk);
    chk("R8_stage_cleared_fuse_burn", W'(fuse_p), W'(1));
    chk("R4_no_rej_first", W'(rej), W'(0));
    step();

    // R9 fallback then R10 empty
    bat_ok = 1'b0;
    look("R9_fuse_fallback", '0);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R10_empty_flag", W'(no_key), W'(1));
    step();
    rst_ni = 1'b1;
    step(); step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule